// File: doc/BRIEF.md
# Barrel Shifter with Condition Flags

This block shifts a 32-bit operand left or right by 0 to 31 places and produces a four-bit condition-flag set (zero, sign, carry, overflow) together with the shifted value. Three operations are available. A logical left shift fills the vacated low bits with zeros. A logical right shift fills the vacated high bits with zeros. An arithmetic right shift copies the operand's top bit into the vacated positions. The shift distance comes from one of two places: a 5-bit immediate field, which is zero-extended, or the low five bits of a second 32-bit register value.

An execution pipeline presents one operation per cycle with `in_valid` high. The shifted value and the new flags appear in registers on the next rising clock edge, and `out_valid` pulses at the same time. When no operation is accepted, the outputs keep their previous values.

Top module: `shf_unit`

## Requirements
- R1: When `amt_from_reg` is 1, the shift distance is `amt_reg[4:0]` and bits 31..5 of `amt_reg` have no effect. When `amt_from_reg` is 0, the distance is `imm_amt`, zero-extended.
- R2: With `op` = 2 (arithmetic right), the result is the operand shifted right, with operand bit 31 copied into every vacated high position.
- R3: With `op` = 1 (logical right), the result is the operand shifted right, with zeros in the vacated high positions.
- R4: With `op` = 0 (logical left), the result is the operand shifted left, with zeros in the vacated low positions.
- R5: For either right shift by n in 1..31, `flag_cy` becomes operand bit n-1.
- R6: For a left shift by n in 1..31, `flag_cy` becomes operand bit 32-n.
- R7: A shift distance of 0 (including a register distance whose low five bits are 0) returns the operand unchanged and clears `flag_cy`.
- R8: Every accepted operation clears `flag_ov`.
- R9: After an accepted operation, `flag_z` is 1 exactly when the result is zero, and `flag_s` equals result bit 31.
- R10: Result and flags update on the rising edge that samples `in_valid` = 1 with a legal `op`. `out_valid` is 1 for that one cycle only. With `in_valid` = 0, or with `op` = 3 (reserved), the result, the flags and `out_valid` = 0 hold.
- R11: Synchronous reset sets the result to 0, `flag_z` to 1, and `flag_s`, `flag_cy`, `flag_ov` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 reserved |
| amt_from_reg | input | 1 | 1: distance from `amt_reg`, 0: from `imm_amt` |
| imm_amt | input | 5 | Immediate shift distance |
| amt_reg | input | 32 | Register value whose low five bits give the distance |
| operand | input | 32 | Value to shift |
| out_valid | output | 1 | One-cycle pulse when the outputs take a new result |
| result | output | 32 | Registered shifted value |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_cy | output | 1 | Last bit shifted out |
| flag_ov | output | 1 | Overflow flag, always cleared by a shift |

## Verification
The assertions assume that `in_valid` and `op` have known values in every cycle after reset. The flag-to-result consistency properties also assume that nothing except an accepted operation or a reset loads the output registers. The bench drives every input from the falling edge, keeps `in_valid` low between vectors, and sets all fields, including unused ones, to defined values. The zero-distance property uses the selected distance, so the bench covers both a zero immediate and a register distance of 32, whose low five bits are zero.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SH_LEFT   = 2'd0,
        SH_RLOG   = 2'd1,
        SH_RARITH = 2'd2,
        SH_RSVD   = 2'd3
    } shf_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
        logic ov;
    } shf_flags_t;

    function automatic logic op_is_legal(shf_op_e o);
        return o != SH_RSVD;
    endfunction

    function automatic logic op_is_left(shf_op_e o);
        return o == SH_LEFT;
    endfunction

endpackage

// File: rtl/shf_amt_sel.sv
module shf_amt_sel #(
    parameter int W  = shf_pkg::DATA_W,
    parameter int AW = shf_pkg::AMT_W
) (
    input  logic          from_reg,
    input  logic [AW-1:0] imm,
    input  logic [W-1:0]  reg_val,
    output logic [AW-1:0] amt
);
    // Only the low AW bits of the register take part (R1).
    assign amt = from_reg ? reg_val[AW-1:0] : imm;
endmodule

// File: rtl/shf_log_core.sv
module shf_log_core #(
    parameter int W  = shf_pkg::DATA_W,
    parameter int AW = shf_pkg::AMT_W
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          left,
    input  logic          fill,
    output logic [W-1:0]  dout,
    output logic          carry
);
    // One guard bit rides along on the side the bits leave from. After
    // the last stage it holds the last bit shifted out, or 0 for distance 0.
    localparam int EW = W + 1;

    logic [EW-1:0] stg [AW+1];

    assign stg[0] = left ? {1'b0, din} : {din, 1'b0};

    for (genvar i = 0; i < AW; i++) begin : g_stage
        localparam int S = 1 << i;
        logic [EW-1:0] shl_v;
        logic [EW-1:0] shr_v;
        assign shl_v = {stg[i][EW-1-S:0], {S{1'b0}}};
        assign shr_v = {{S{fill}}, stg[i][EW-1:S]};
        assign stg[i+1] = !amt[i] ? stg[i] : (left ? shl_v : shr_v);
    end

    assign dout  = left ? stg[AW][W-1:0] : stg[AW][W:1];
    assign carry = left ? stg[AW][W]     : stg[AW][0];
endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
    import shf_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    input  logic         carry,
    output shf_flags_t   flags
);
    always_comb begin
        flags.z  = (res == '0);
        flags.s  = res[W-1];
        flags.cy = carry;
        flags.ov = 1'b0;
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = AMT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    op,
    input  logic          amt_from_reg,
    input  logic [AW-1:0] imm_amt,
    input  logic [W-1:0]  amt_reg,
    input  logic [W-1:0]  operand,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic          flag_z,
    output logic          flag_s,
    output logic          flag_cy,
    output logic          flag_ov
);
    shf_op_e       op_e;
    logic [AW-1:0] amt;
    logic [W-1:0]  shifted;
    logic          carry;
    logic          fill;
    logic          accept;
    shf_flags_t    next_flags;
    shf_flags_t    flags_q;
    logic [W-1:0]  result_q;
    logic          valid_q;

    assign op_e   = shf_op_e'(op);
    assign accept = in_valid && op_is_legal(op_e);
    assign fill   = (op_e == SH_RARITH) ? operand[W-1] : 1'b0;

    shf_amt_sel #(.W(W), .AW(AW)) u_amt (
        .from_reg (amt_from_reg),
        .imm      (imm_amt),
        .reg_val  (amt_reg),
        .amt      (amt)
    );

    shf_log_core #(.W(W), .AW(AW)) u_core (
        .din   (operand),
        .amt   (amt),
        .left  (op_is_left(op_e)),
        .fill  (fill),
        .dout  (shifted),
        .carry (carry)
    );

    shf_flag_gen #(.W(W)) u_flags (
        .res   (shifted),
        .carry (carry),
        .flags (next_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '{z: 1'b1, s: 1'b0, cy: 1'b0, ov: 1'b0};
            valid_q  <= 1'b0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                result_q <= shifted;
                flags_q  <= next_flags;
            end
        end
    end

    assign out_valid = valid_q;
    assign result    = result_q;
    assign flag_z    = flags_q.z;
    assign flag_s    = flags_q.s;
    assign flag_cy   = flags_q.cy;
    assign flag_ov   = flags_q.ov;

    // R8: overflow never set by any shift
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> !flag_ov);

    // R9: zero flag agrees with the stored result
    p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
        flag_z == (result == '0));

    // R9: sign flag agrees with the stored result
    p_sign_flag_r9: assert property (@(posedge clk) disable iff (rst)
        flag_s == result[W-1]);

    // R10: no accepted operation leaves outputs untouched
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(result) && $stable(flags_q) && !out_valid));

    // R7: distance zero passes operand through and clears carry
    p_zero_dist_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && amt == '0) |=> (result == $past(operand) && !flag_cy));

    // R4: a left shift never leaves ones below the distance
    p_left_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && op_e == SH_LEFT && amt != '0) |=> !result[0]);
endmodule

// File: tb/tb_shf_unit.sv
module tb_shf_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic        amt_from_reg;
    logic [4:0]  imm_amt;
    logic [31:0] amt_reg;
    logic [31:0] operand;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_z, flag_s, flag_cy, flag_ov;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    shf_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .amt_from_reg(amt_from_reg), .imm_amt(imm_amt), .amt_reg(amt_reg),
        .operand(operand), .out_valid(out_valid), .result(result),
        .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy), .flag_ov(flag_ov)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        src;
        logic [4:0]  imm;
        logic [31:0] ramt;
        logic [31:0] opnd;
        logic [31:0] exp;
        logic        cy;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 5'd4,  32'h0,         32'h1000_000F, 32'h0000_00F0, 1'b1}, // R4 R6
        '{2'd1, 1'b0, 5'd8,  32'h0,         32'h8000_0180, 32'h0080_0001, 1'b1}, // R3 R5
        '{2'd2, 1'b0, 5'd8,  32'h0,         32'h8000_0180, 32'hFF80_0001, 1'b1}, // R2 R5
        '{2'd2, 1'b1, 5'd0,  32'hFFFF_FFE4, 32'h7FFF_FFF7, 32'h07FF_FFFF, 1'b0}, // R1 R2
        '{2'd1, 1'b0, 5'd31, 32'h0,         32'h8000_0000, 32'h0000_0001, 1'b0}, // R3
        '{2'd0, 1'b0, 5'd1,  32'h0,         32'h8000_0000, 32'h0000_0000, 1'b1}, // R6 R9
        '{2'd2, 1'b0, 5'd31, 32'h0,         32'h8000_0000, 32'hFFFF_FFFF, 1'b0}, // R2
        '{2'd0, 1'b0, 5'd0,  32'h0,         32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0}, // R7
        '{2'd1, 1'b1, 5'd7,  32'h0000_0020, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R7 R1
        '{2'd1, 1'b0, 5'd1,  32'h0,         32'h0000_0001, 32'h0000_0000, 1'b1}, // R5 R9
        '{2'd0, 1'b1, 5'd3,  32'h0000_0041, 32'h4000_0001, 32'h8000_0002, 1'b0}, // R1 R6
        '{2'd0, 1'b0, 5'd31, 32'h0,         32'h0000_0003, 32'h8000_0000, 1'b1}  // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] o, input logic src, input logic [4:0] im,
                         input logic [31:0] ra, input logic [31:0] od, input logic v);
        @(negedge clk);
        op = o; amt_from_reg = src; imm_amt = im; amt_reg = ra; operand = od;
        in_valid = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 2'd0; amt_from_reg = 1'b0;
        imm_amt = 5'd0; amt_reg = 32'h0; operand = 32'h0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 result", result, 32'h0);
        check("R11 flags zscv", {28'h0, flag_z, flag_s, flag_cy, flag_ov}, 32'h8);
        check("R11 out_valid", {31'h0, out_valid}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].src, VEC[i].imm, VEC[i].ramt, VEC[i].opnd, 1'b1);
            check($sformatf("R1-R7 vec%0d result", i), result, VEC[i].exp);
            check($sformatf("R5 R6 R7 vec%0d carry", i), {31'h0, flag_cy}, {31'h0, VEC[i].cy});
            check($sformatf("R9 vec%0d z s", i), {30'h0, flag_z, flag_s},
                  {30'h0, VEC[i].exp == 32'h0, VEC[i].exp[31]});
            check($sformatf("R8 vec%0d ov", i), {31'h0, flag_ov}, 32'h0);
            check($sformatf("R10 vec%0d out_valid", i), {31'h0, out_valid}, 32'h1);
        end

        // R10: out_valid lasts one cycle; last vector left result 0x80000000
        @(negedge clk);
        check("R10 pulse ends", {31'h0, out_valid}, 32'h0);

        // R10: inputs change without in_valid -> hold
        issue(2'd1, 1'b0, 5'd4, 32'h0, 32'hFFFF_0000, 1'b0);
        check("R10 idle hold result", result, 32'h8000_0000);
        check("R10 idle hold flags", {28'h0, flag_z, flag_s, flag_cy, flag_ov}, 32'h6);

        // R10: reserved op ignored
        issue(2'd3, 1'b0, 5'd4, 32'h0, 32'h0000_0000, 1'b1);
        check("R10 reserved result", result, 32'h8000_0000);
        check("R10 reserved flags", {28'h0, flag_z, flag_s, flag_cy, flag_ov}, 32'h6);
        check("R10 reserved out_valid", {31'h0, out_valid}, 32'h0);

        // R1: upper register bits ignored, immediate ignored when from register
        issue(2'd1, 1'b1, 5'd31, 32'hABCD_EF02, 32'h0000_00F0, 1'b1);
        check("R1 reg low bits only", result, 32'h0000_003C);

        // R11: reset after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R11 re-reset result", result, 32'h0);
        check("R11 re-reset flags", {28'h0, flag_z, flag_s, flag_cy, flag_ov}, 32'h8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule